// File: doc/BRIEF.md
# Floating-Point Store Request Formatter

This block turns one floating-point store operation into one memory write request. Each cycle it may accept an operation code, the 64-bit value of the source floating-point register, a base operand with a flag saying the base register index is zero, a 16-bit displacement and an index operand. From these it forms the effective address, picks the access size and lays out the store data. The request comes out of a register on the next cycle.

Five operations are supported. Single-precision stores narrow the double-format value to 32-bit single format. Double-precision stores pass all 64 bits through unchanged. A word store copies the low 32 bits of the register without any format change. Displacement and indexed forms differ only in the second addend of the address.

The request stage is a two-state machine. `RS_IDLE` means no request is presented. `RS_EMIT` means a request is on the outputs. The transition `IDLE->EMIT` and the self-loop `EMIT->EMIT` are taken when a legal operation is accepted. `EMIT->IDLE` is taken when none is accepted, and `IDLE->IDLE` is the no-operation hold.

Top module: `fp_store_fmt`

## Requirements
- R1: When `in_base_idx_zero` is 1 the base addend is zero whatever `in_base` holds; when it is 0 the base addend is `in_base`.
- R2: Displacement-form operations (op 0 single, op 2 double) use as address the base addend plus the sign-extended 16-bit `in_disp`, modulo 2^64.
- R3: Indexed-form operations (op 1 single, op 3 double, op 4 word) use as address the base addend plus `in_index`, modulo 2^64; `in_disp` is ignored.
- R4: Single-precision stores (op 0, op 1) give `req_size` = 4, put the single-format value in `req_data[31:0]` and drive `req_data[63:32]` to zero.
- R5: Single-format conversion: bit 31 is source bit 63 and bits 22:0 are source bits 51:29. Bits 30:23 hold the exponent. A source exponent field of 0x7FF gives 0xFF, and 0 gives 0. Any other source exponent e gives the low 8 bits of e − 896.
- R6: Double-precision stores (op 2, op 3) give `req_size` = 8 and `req_data` equal to `in_frs` unchanged.
- R7: The word store (op 4) gives `req_size` = 4, `req_data[31:0]` = `in_frs[31:0]`, and zero in `req_data[63:32]`.
- R8: Each clock edge that sees `in_valid` high with a legal op (0 to 4) makes `req_valid` high for the following cycle only. Back-to-back inputs give back-to-back requests.
- R9: An edge with `in_valid` low, or with an op code of 5, 6 or 7, is followed by a cycle with `req_valid` low.
- R10: While `rst_n` is low, `req_valid`, `req_addr`, `req_size` and `req_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered this cycle |
| in_op | input | 3 | Operation code: 0..4 legal, 5..7 rejected |
| in_frs | input | 64 | Source floating-point register value |
| in_base | input | 64 | Base register value |
| in_base_idx_zero | input | 1 | Base register index is zero; base addend forced to 0 |
| in_disp | input | 16 | Signed displacement for displacement forms |
| in_index | input | 64 | Index register value for indexed forms |
| req_valid | output | 1 | Write request present |
| req_addr | output | 64 | Effective address |
| req_size | output | 4 | Bytes to write, 4 or 8 |
| req_data | output | 64 | Store data, right-aligned |

## Verification
The bench mixes fixed-seed random operations with directed cases. Random base, index and displacement values, with the zero-index flag set about a quarter of the time, show whether the two address forms and the base override are selected per operation. Directed negative displacements and near-top bases show sign extension and modulo-2^64 wrap apart from plain addition. Source values of one, negative numbers, infinity, NaN and zero separate the normal exponent rebase from the two special exponent paths. Rejected op codes and idle gaps placed between back-to-back requests show that a request lasts exactly one cycle.

// File: rtl/fps_pkg.sv
package fps_pkg;

    // Operation codes presented on in_op
    typedef enum logic [2:0] {
        FOP_SGL_D = 3'd0,
        FOP_SGL_X = 3'd1,
        FOP_DBL_D = 3'd2,
        FOP_DBL_X = 3'd3,
        FOP_WRD_X = 3'd4
    } fop_e;

    // Data layout chosen by the formatter
    typedef enum logic [1:0] {
        FK_SINGLE = 2'd0,
        FK_DOUBLE = 2'd1,
        FK_WORD   = 2'd2
    } fkind_e;

    // Request stage states
    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_EMIT = 1'b1
    } rstate_e;

    localparam int unsigned SIZE_W = 4;

endpackage

// File: rtl/fps_agen.sv
module fps_agen #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic              base_is_zero,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              use_index,
    output logic [ADDR_W-1:0] ea
);
    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] off_term;

    always_comb begin
        base_term = base_is_zero ? '0 : base_val;
        disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
        off_term  = use_index ? index_val : disp_ext;
        ea        = base_term + off_term;
    end
endmodule

// File: rtl/fps_fmt.sv
module fps_fmt
    import fps_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] frs,
    input  fkind_e            kind,
    output logic [DATA_W-1:0] data,
    output logic [SIZE_W-1:0] size
);
    // Double format field layout
    localparam int unsigned DEXP_W  = 11;
    localparam int unsigned DFRAC_W = 52;
    // Single format field layout
    localparam int unsigned SEXP_W  = 8;
    localparam int unsigned SFRAC_W = 23;
    localparam int unsigned SGL_W   = 1 + SEXP_W + SFRAC_W;
    localparam int unsigned PAD_W   = DATA_W - SGL_W;
    localparam int unsigned DBIAS   = (1 << (DEXP_W - 1)) - 1;
    localparam int unsigned SBIAS   = (1 << (SEXP_W - 1)) - 1;
    localparam logic [DEXP_W-1:0] REBASE  = DEXP_W'(DBIAS - SBIAS);
    localparam logic [DEXP_W-1:0] DEXP_HI = '1;
    localparam logic [SIZE_W-1:0] SZ_WORD = SIZE_W'(SGL_W / 8);
    localparam logic [SIZE_W-1:0] SZ_DBL  = SIZE_W'(DATA_W / 8);

    logic                 sgn;
    logic [DEXP_W-1:0]    dexp;
    logic [SFRAC_W-1:0]   frac_top;
    logic [DEXP_W-1:0]    rebased;
    logic [SEXP_W-1:0]    sexp;
    logic [SGL_W-1:0]     sgl;

    always_comb begin
        sgn      = frs[DATA_W-1];
        dexp     = frs[DATA_W-2 -: DEXP_W];
        frac_top = frs[DFRAC_W-1 -: SFRAC_W];
        rebased  = dexp - REBASE;
        if (dexp == DEXP_HI) begin
            sexp = '1;
        end else if (dexp == '0) begin
            sexp = '0;
        end else begin
            sexp = rebased[SEXP_W-1:0];
        end
        sgl = {sgn, sexp, frac_top};
    end

    always_comb begin
        unique case (kind)
            FK_DOUBLE: begin
                data = frs;
                size = SZ_DBL;
            end
            FK_WORD: begin
                data = {{PAD_W{1'b0}}, frs[SGL_W-1:0]};
                size = SZ_WORD;
            end
            default: begin
                data = {{PAD_W{1'b0}}, sgl};
                size = SZ_WORD;
            end
        endcase
    end
endmodule

// File: rtl/fps_req_stage.sv
module fps_req_stage
    import fps_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] ea,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] data,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SIZE_W-1:0] req_size,
    output logic [DATA_W-1:0] req_data
);
    rstate_e state_q;
    rstate_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: state_d = take ? RS_EMIT : RS_IDLE;
            RS_EMIT: state_d = take ? RS_EMIT : RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output payload register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr <= '0;
            req_size <= '0;
            req_data <= '0;
        end else if (take) begin
            req_addr <= ea;
            req_size <= size;
            req_data <= data;
        end
    end

    assign req_valid = (state_q == RS_EMIT);
endmodule

// File: rtl/fp_store_fmt.sv
module fp_store_fmt
    import fps_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [DATA_W-1:0] in_frs,
    input  logic [ADDR_W-1:0] in_base,
    input  logic              in_base_idx_zero,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [ADDR_W-1:0] in_index,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [3:0]        req_size,
    output logic [DATA_W-1:0] req_data
);
    logic              op_legal;
    logic              op_indexed;
    fkind_e            op_kind;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] fmt_data;
    logic [SIZE_W-1:0] fmt_size;

    always_comb begin
        op_legal   = 1'b1;
        op_indexed = 1'b0;
        op_kind    = FK_SINGLE;
        unique case (in_op)
            FOP_SGL_D: begin op_kind = FK_SINGLE; end
            FOP_SGL_X: begin op_kind = FK_SINGLE; op_indexed = 1'b1; end
            FOP_DBL_D: begin op_kind = FK_DOUBLE; end
            FOP_DBL_X: begin op_kind = FK_DOUBLE; op_indexed = 1'b1; end
            FOP_WRD_X: begin op_kind = FK_WORD;   op_indexed = 1'b1; end
            default:   begin op_legal = 1'b0; end
        endcase
    end

    fps_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
        .base_val     (in_base),
        .base_is_zero (in_base_idx_zero),
        .disp         (in_disp),
        .index_val    (in_index),
        .use_index    (op_indexed),
        .ea           (ea)
    );

    fps_fmt #(.DATA_W(DATA_W)) u_fmt (
        .frs  (in_frs),
        .kind (op_kind),
        .data (fmt_data),
        .size (fmt_size)
    );

    fps_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (in_valid && op_legal),
        .ea        (ea),
        .size      (fmt_size),
        .data      (fmt_data),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_data  (req_data)
    );
endmodule

// File: rtl/fp_store_fmt_chk.sv
module fp_store_fmt_chk #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned DISP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [DATA_W-1:0] in_frs,
    input logic [ADDR_W-1:0] in_base,
    input logic              in_base_idx_zero,
    input logic [DISP_W-1:0] in_disp,
    input logic [ADDR_W-1:0] in_index,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_size,
    input logic [DATA_W-1:0] req_data
);
    localparam int unsigned EXT_W = ADDR_W - DISP_W;
    localparam int unsigned HALF  = DATA_W / 2;

    logic legal_in;
    assign legal_in = in_valid && (in_op <= 3'd4);

    assert_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> req_valid);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_in |=> !req_valid);

    assert_size_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_size == 4'd4 || req_size == 4'd8));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 4'd4) |-> (req_data[DATA_W-1:HALF] == '0));

    assert_base_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_in && in_base_idx_zero && in_op == 3'd2) |=>
        (req_addr == {{EXT_W{$past(in_disp[DISP_W-1])}}, $past(in_disp)}));

    assert_index_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_in && !in_base_idx_zero && in_op == 3'd3) |=>
        (req_addr == $past(in_base) + $past(in_index)));

    assert_double_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_in && (in_op == 3'd2 || in_op == 3'd3)) |=>
        (req_data == $past(in_frs) && req_size == 4'd8));

    assert_word_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_in && in_op == 3'd4) |=>
        (req_data[HALF-1:0] == $past(in_frs[HALF-1:0]) && req_size == 4'd4));
endmodule

bind fp_store_fmt fp_store_fmt_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .in_op            (in_op),
    .in_frs           (in_frs),
    .in_base          (in_base),
    .in_base_idx_zero (in_base_idx_zero),
    .in_disp          (in_disp),
    .in_index         (in_index),
    .req_valid        (req_valid),
    .req_addr         (req_addr),
    .req_size         (req_size),
    .req_data         (req_data)
);

// File: tb/test_fp_store_fmt.sv
module test_fp_store_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [63:0] in_frs = '0;
    logic [63:0] in_base = '0;
    logic        in_base_idx_zero = 1'b0;
    logic [15:0] in_disp = '0;
    logic [63:0] in_index = '0;
    logic        req_valid;
    logic [63:0] req_addr;
    logic [3:0]  req_size;
    logic [63:0] req_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fp_store_fmt i_fp_store_fmt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_frs(in_frs), .in_base(in_base), .in_base_idx_zero(in_base_idx_zero),
        .in_disp(in_disp), .in_index(in_index), .req_valid(req_valid),
        .req_addr(req_addr), .req_size(req_size), .req_data(req_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R5 reference narrowing
    function automatic logic [31:0] ref_single(input logic [63:0] d);
        logic [10:0] e;
        logic [10:0] t;
        e = d[62:52];
        t = e - 11'd896;
        if (e == 11'h7FF) return {d[63], 8'hFF, d[51:29]};
        if (e == 11'h000) return {d[63], 8'h00, d[51:29]};
        return {d[63], t[7:0], d[51:29]};
    endfunction

    function automatic logic [63:0] ref_addr(input logic [2:0] op, input logic [63:0] b,
                                             input logic bz, input logic [15:0] dsp,
                                             input logic [63:0] ix);
        logic [63:0] bb;
        bb = bz ? 64'd0 : b;
        if (op == 3'd1 || op == 3'd3 || op == 3'd4) return bb + ix;   // R3
        return bb + {{48{dsp[15]}}, dsp};                               // R2
    endfunction

    task automatic send(input logic [2:0] op, input logic [63:0] frs, input logic [63:0] b,
                        input logic bz, input logic [15:0] dsp, input logic [63:0] ix);
        in_valid = 1'b1; in_op = op; in_frs = frs; in_base = b;
        in_base_idx_zero = bz; in_disp = dsp; in_index = ix;
        @(negedge clk);
        if (op > 3'd4) begin
            chk("R9 illegal op no request", {63'd0, req_valid}, 64'd0);
        end else begin
            chk("R8 request valid", {63'd0, req_valid}, 64'd1);
            chk(bz ? "R1 address" : "R2/R3 address", req_addr, ref_addr(op, b, bz, dsp, ix));
            case (op)
                3'd0, 3'd1: begin
                    chk("R4 size", {60'd0, req_size}, 64'd4);
                    chk("R4 R5 data", req_data, {32'd0, ref_single(frs)});
                end
                3'd2, 3'd3: begin
                    chk("R6 size", {60'd0, req_size}, 64'd8);
                    chk("R6 data", req_data, frs);
                end
                default: begin
                    chk("R7 size", {60'd0, req_size}, 64'd4);
                    chk("R7 data", req_data, {32'd0, frs[31:0]});
                end
            endcase
        end
        in_valid = 1'b0;
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 R9 idle no request", {63'd0, req_valid}, 64'd0);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0DE_1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 valid", {63'd0, req_valid}, 64'd0);
        chk("R10 addr", req_addr, 64'd0);
        chk("R10 size", {60'd0, req_size}, 64'd0);
        chk("R10 data", req_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 base forced to zero with negative displacement
        send(3'd2, 64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0000_1000, 1'b1, 16'h8000, 64'd0);
        chk("R1 literal", req_addr, 64'hFFFF_FFFF_FFFF_8000);
        // R2 wrap past the top
        send(3'd0, 64'h3FF0_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 16'h0020, 64'd0);
        chk("R2 wrap", req_addr, 64'h0000_0000_0000_0010);
        chk("R5 one", req_data, 64'h0000_0000_3F80_0000);
        // R3 indexed ignores displacement
        send(3'd1, 64'hC004_0000_0000_0000, 64'h1000, 1'b0, 16'h7FFF, 64'h20);
        chk("R3 literal", req_addr, 64'h1020);
        chk("R5 neg", req_data, 64'h0000_0000_C020_0000);
        send(3'd1, 64'h7FF0_0000_0000_0000, 64'h0, 1'b0, 16'h0, 64'h8);
        chk("R5 inf", req_data, 64'h0000_0000_7F80_0000);
        send(3'd0, 64'h7FF8_0000_0000_0001, 64'h40, 1'b1, 16'hFFFC, 64'h0);
        chk("R5 nan", req_data, 64'h0000_0000_7FC0_0000);
        send(3'd0, 64'h8000_0000_0000_0000, 64'h40, 1'b0, 16'hFFFC, 64'h0);
        chk("R5 neg zero", req_data, 64'h0000_0000_8000_0000);
        send(3'd3, 64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 16'h0, 64'h2);
        send(3'd4, 64'hAAAA_BBBB_CCCC_DDDD, 64'h5555, 1'b1, 16'h1234, 64'h100);
        chk("R7 literal", req_data, 64'h0000_0000_CCCC_DDDD);
        idle_cycle();
        send(3'd5, 64'h1, 64'h2, 1'b0, 16'h3, 64'h4);
        send(3'd7, 64'h1, 64'h2, 1'b0, 16'h3, 64'h4);
        idle_cycle();

        for (int i = 0; i < 600; i++) begin
            logic [2:0]  op;
            logic [63:0] frs;
            logic [63:0] b;
            logic [63:0] ix;
            op  = 3'($urandom_range(0, 7));
            frs = {$urandom(), $urandom()};
            b   = {$urandom(), $urandom()};
            ix  = {$urandom(), $urandom()};
            send(op, frs, b, ($urandom_range(0, 3) == 0), 16'($urandom()), ix);
            if ($urandom_range(0, 4) == 0) idle_cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule